// File: doc/BRIEF.md
# Priority-Ordered Interrupt Unit

This block collects sixteen interrupt sources and drives a single request line to the processor core. Eight of the sources are external pins, which are active low and asynchronous. The other eight are internal level lines, which are synchronous and active high. The two kinds alternate in one fixed priority chain: source 0 is pin 0, source 1 is internal line 0, source 2 is pin 1, and so on. Source 0 has the highest priority.

Each pin can be configured in one of two ways:

- **Level mode:** the pending bit follows the pin, after a two-flop synchroniser.
- **Edge mode:** a falling edge sets a sticky bit, and software clears that bit by writing a one to it.

Software uses a single-cycle register port with four registers: pending, mask, vector and edge select. Inside the 32-bit word, source n always sits at bit 31-n. The vector register reports the winning source's code in its top six bits.

A handler reads the vector, narrows the mask, acknowledges edge sources through the pending register and restores the mask afterwards. The core request stays asserted for as long as any unmasked source is still pending.

Top module: `prio_irq_unit`

## Requirements
- R1: After reset the mask is all zero, no edge bit is latched, the vector reads 0x40000000 (code 16) and `irq_o` is low.
- R2: Source n (0..15) maps to bit 31-n of the pending and mask words. Even n is pin n/2 and odd n is internal line (n-1)/2. Bits 15:0 read as zero.
- R3: In level mode a pin's pending bit is the inverse of the pin. The bit reflects a pin change from the second rising clock edge after the change.
- R4: In edge mode a falling pin edge sets a sticky pending bit by the third rising edge. The bit remains set after the pin returns high.
- R5: Writing 1 to a pending bit clears a latched edge source, and a 0 bit in the write leaves it alone. The write never changes an internal line's pending bit. Writing 0xFFFF0000 clears every latched edge at once.
- R6: The vector register holds, in bits 31:26, the lowest index that is both pending and unmasked. Bits 25:0 read zero.
- R7: With nothing pending and unmasked, the vector field reads code 16.
- R8: `irq_o` is high exactly when pending AND mask is nonzero. It rises again when a cleared mask is restored while a source is still pending.
- R9: Mask (address 1) and edge select (address 3) are read/write. The edge-select bit for pin k is bit 31-2k, and all other edge-select bits read zero. Writes to bits 15:0 of any register have no effect.
- R10: Address 0 is pending, 1 is mask, 2 is vector and 3 is edge select. Writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_ni | input | 8 | External request pins, active low, asynchronous |
| int_lvl_i | input | 8 | Internal level request lines, active high, synchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Request to the core |

## Verification
The assertions take the following for granted:

- Internal level lines are already synchronous to `clk_i`.
- The register strobe, address and data are stable around each rising edge.
- The edge-select setting of a pin does not change while that pin is toggling.

The stimulus respects all three. Every input is driven on the falling edge, and edge select is configured while all pins are idle and high. Pin pulses are held low for two full cycles so that the synchroniser captures them.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1,
    REG_VEC  = 2'd2,
    REG_ESEL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
  parameter int unsigned N_PIN      = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_ni,
  input  logic [N_PIN-1:0] edge_sel_i,
  input  logic [N_PIN-1:0] clr_i,
  output logic [N_PIN-1:0] pend_o
);
  localparam int unsigned MSB = SYNC_DEPTH - 1;

  for (genvar k = 0; k < N_PIN; k++) begin : g_pin
    logic [SYNC_DEPTH-1:0] chain_q;
    logic                  prev_q;
    logic                  sticky_q;
    logic                  fall;

    assign fall = prev_q & ~chain_q[MSB];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q  <= '1;
        prev_q   <= 1'b1;
        sticky_q <= 1'b0;
      end else begin
        chain_q  <= {chain_q[SYNC_DEPTH-2:0], pin_ni[k]};
        prev_q   <= chain_q[MSB];
        // a new edge wins over a same-cycle acknowledge
        sticky_q <= edge_sel_i[k] & (fall | (sticky_q & ~clr_i[k]));
      end
    end

    assign pend_o[k] = edge_sel_i[k] ? sticky_q : ~chain_q[MSB];

    p_edge_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_sel_i[k] && fall) |=> pend_o[k] || !edge_sel_i[k]);

    p_sticky_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_sel_i[k] && pend_o[k] && !clr_i[k]) |=> sticky_q);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned VEC_W = 6
) (
  input  logic [N_SRC-1:0] act_i,
  output logic             vld_o,
  output logic [VEC_W-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = VEC_W'(N_SRC);
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        vld_o = 1'b1;
        idx_o = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_unit.sv
module prio_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned N_PIN      = 8,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned VEC_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIN-1:0]  ext_irq_ni,
  input  logic [N_PIN-1:0]  int_lvl_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned N_SRC = 2 * N_PIN;
  localparam int unsigned TOP   = WORD_W - 1;

  reg_addr_e              addr;
  logic [N_SRC-1:0]       mask_q;
  logic [N_PIN-1:0]       esel_q;
  logic [N_PIN-1:0]       pin_pend;
  logic [N_PIN-1:0]       pin_clr;
  logic [N_SRC-1:0]       src_pend;
  logic [N_SRC-1:0]       src_act;
  logic                   vec_vld;
  logic [VEC_W-1:0]       vec_idx;
  logic [WORD_W-1:0]      pend_word, mask_word, esel_word, vec_word;
  logic                   wr_pend, wr_mask, wr_esel;
  logic                   unused_wdata;

  assign addr    = reg_addr_e'(reg_addr_i);
  assign wr_pend = reg_we_i && (addr == REG_PEND);
  assign wr_mask = reg_we_i && (addr == REG_MASK);
  assign wr_esel = reg_we_i && (addr == REG_ESEL);
  assign unused_wdata = ^reg_wdata_i[TOP-N_SRC:0];

  for (genvar k = 0; k < N_PIN; k++) begin : g_map
    assign pin_clr[k]      = wr_pend & reg_wdata_i[TOP-2*k];
    assign src_pend[2*k]   = pin_pend[k];
    assign src_pend[2*k+1] = int_lvl_i[k];
  end

  irq_pin_front #(
    .N_PIN     (N_PIN),
    .SYNC_DEPTH(SYNC_DEPTH)
  ) i_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_ni    (ext_irq_ni),
    .edge_sel_i(esel_q),
    .clr_i     (pin_clr),
    .pend_o    (pin_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      esel_q <= '0;
    end else begin
      if (wr_mask) begin
        for (int n = 0; n < N_SRC; n++) mask_q[n] <= reg_wdata_i[TOP-n];
      end
      if (wr_esel) begin
        for (int k = 0; k < N_PIN; k++) esel_q[k] <= reg_wdata_i[TOP-2*k];
      end
    end
  end

  assign src_act = src_pend & mask_q;

  irq_prio_enc #(
    .N_SRC(N_SRC),
    .VEC_W(VEC_W)
  ) i_enc (
    .act_i(src_act),
    .vld_o(vec_vld),
    .idx_o(vec_idx)
  );

  always_comb begin
    pend_word = '0;
    mask_word = '0;
    esel_word = '0;
    for (int n = 0; n < N_SRC; n++) begin
      pend_word[TOP-n] = src_pend[n];
      mask_word[TOP-n] = mask_q[n];
    end
    for (int k = 0; k < N_PIN; k++) esel_word[TOP-2*k] = esel_q[k];
    vec_word = {vec_idx, {(WORD_W-VEC_W){1'b0}}};
  end

  always_comb begin
    unique case (addr)
      REG_PEND: reg_rdata_o = pend_word;
      REG_MASK: reg_rdata_o = mask_word;
      REG_VEC:  reg_rdata_o = vec_word;
      REG_ESEL: reg_rdata_o = esel_word;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(pend_word & mask_word);

  p_irq_vec_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == vec_vld);

  p_none_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_idx == VEC_W'(N_SRC)));

  p_winner_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld |-> (pend_word[TOP-vec_idx] && mask_word[TOP-vec_idx]));

  p_no_higher_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld |-> ((src_act & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0));

  p_mask_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));

  p_esel_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_esel |=> $stable(esel_q));
endmodule

// File: tb/test_prio_irq_unit.sv
module test_prio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  ext_irq_ni = 8'hff;
  logic [7:0]  int_lvl_i = 8'h00;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_unit i_prio_irq_unit (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ext_irq_ni (ext_irq_ni),
    .int_lvl_i  (int_lvl_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1;
    reg_addr_i = a;
    reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
    reg_wdata_i = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] to_word(input logic [15:0] s);
    logic [31:0] w = '0;
    for (int n = 0; n < 16; n++) w[31-n] = s[n];
    return w;
  endfunction

  function automatic logic [31:0] exp_vec(input logic [15:0] a);
    int idx = 16;
    for (int n = 0; n < 16; n++) begin
      if (a[n]) begin
        idx = n;
        break;
      end
    end
    return 32'(idx) << 26;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] src, msk;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    settle();

    // R1 reset state
    rd(2'd0, d); chk("R1 pending", d, 32'h0);
    rd(2'd1, d); chk("R1 mask", d, 32'h0);
    rd(2'd2, d); chk("R1 vector", d, 32'h4000_0000);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R9 register read/write, R10 vector read-only
    wr(2'd1, 32'hffff_ffff);
    rd(2'd1, d); chk("R9 mask rw", d, 32'hffff_0000);
    wr(2'd3, 32'hffff_ffff);
    rd(2'd3, d); chk("R9 esel rw", d, 32'haaaa_0000);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R9 esel clear", d, 32'h0);
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, d); chk("R10 vector write ignored", d, 32'h4000_0000);
    rd(2'd1, d); chk("R10 vector write no side effect", d, 32'hffff_0000);

    // R2 R3 R6 R7 R8 sweep in level mode
    for (int i = 0; i < 240; i++) begin
      if (i < 16) begin
        src = 16'(1 << i);
        msk = 16'hffff;
      end else begin
        src = 16'((i * 40503) ^ (i << 7));
        msk = 16'((i * 25173 + 13849) >> 3);
      end
      wr(2'd1, to_word(msk) | 32'h0000_ffff);
      for (int k = 0; k < 8; k++) begin
        ext_irq_ni[k] = ~src[2*k];
        int_lvl_i[k]  = src[2*k+1];
      end
      settle();
      rd(2'd0, d); chk("R2 R3 pending map", d, to_word(src));
      rd(2'd2, d); chk("R6 R7 vector", d, exp_vec(src & msk));
      chk("R8 irq", {31'b0, irq_o}, {31'b0, |(src & msk)});
    end

    // R3 release: level-mode pin high clears pending
    ext_irq_ni = 8'hff;
    int_lvl_i = 8'h00;
    settle();
    rd(2'd0, d); chk("R3 release", d, 32'h0);

    // R4 edge mode capture per pin
    wr(2'd3, 32'hffff_0000);
    wr(2'd0, 32'hffff_0000);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ext_irq_ni[k] = 1'b0;
      repeat (2) @(negedge clk);
      ext_irq_ni[k] = 1'b1;
      settle();
      rd(2'd0, d);
      chk("R4 sticky edge", d[31-2*k], 32'h1);
    end
    rd(2'd0, d); chk("R4 all edges latched", d, 32'haaaa_0000);

    // R5 acknowledge behaviour
    int_lvl_i = 8'hff;
    settle();
    rd(2'd0, d); chk("R5 with levels", d, 32'hffff_0000);
    wr(2'd0, 32'hc000_0000);
    rd(2'd0, d); chk("R5 clear pin0 not lvl0", d, 32'h7fff_0000);
    wr(2'd0, 32'h0000_ffff);
    rd(2'd0, d); chk("R5 R9 low bits ignored", d, 32'h7fff_0000);
    wr(2'd0, 32'hffff_0000);
    rd(2'd0, d); chk("R5 bulk clear", d, 32'h5555_0000);
    int_lvl_i = 8'h00;
    settle();
    rd(2'd0, d); chk("R5 levels gone", d, 32'h0);

    // R8 mask restore while still pending
    @(negedge clk);
    ext_irq_ni[1] = 1'b0;
    repeat (2) @(negedge clk);
    ext_irq_ni[1] = 1'b1;
    settle();
    wr(2'd1, 32'h2000_0000);
    #1; chk("R8 irq set", {31'b0, irq_o}, 32'h1);
    wr(2'd1, 32'h0);
    #1; chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
    rd(2'd2, d); chk("R7 vector masked", d, 32'h4000_0000);
    wr(2'd1, 32'h2000_0000);
    #1; chk("R8 irq after restore", {31'b0, irq_o}, 32'h1);
    rd(2'd2, d); chk("R6 vector pin1", d, 32'h0800_0000);
    wr(2'd0, 32'h2000_0000);
    #1; chk("R8 irq after ack", {31'b0, irq_o}, 32'h0);
    rd(2'd2, d); chk("R7 vector after ack", d, 32'h4000_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule